// File: doc/BRIEF.md
# Sticky Interrupt Aggregator

This block gathers a set of peripheral interrupt lines into a single interrupt request towards a processor. Every incoming line is first brought into the local clock domain by a two-flop synchroniser. It is then captured into a pending (sticky) bit, either as a level or on a chosen edge. Software owns a mask of enabled sources, a pair of trigger-mode words and the pending bits, all reached over a simple 32-bit register bus with address, write strobe, write data and read data.

The pending bits are cleared by writing ones. The mask can be written whole, or changed bit by bit through separate set and clear aliases, so that one driver path never has to read, modify and write the mask. A read-only identity view shows the sources that are both pending and enabled. The processor line is the registered OR of that view.

Top module: `irq_sticky_agg`

## Requirements
- R1: After synchronous reset, the pending bits, the mask and both trigger words are zero, every register reads as zero and `cpu_irq` is low.
- R2: A source whose bit is clear in both trigger words is level-captured. Its pending bit is set on every cycle its synchronised input is high, so a clear written while the input is still high is overridden.
- R3: A write to the pending register at byte address 0x10 clears each bit written as 1 and leaves every bit written as 0 unchanged. If a capture and a clear hit the same bit in the same cycle, the bit ends up set.
- R4: A write to the set alias at 0x20 ORs the written bits into the mask. A write to the clear alias at 0x1C removes the written bits. Neither alias changes any other mask bit.
- R5: A write to the mask at 0x18 replaces it with the written value. Writing zero masks every source at once.
- R6: The identity register at 0x38 reads as the bitwise AND of the pending bits and the mask. Writes to it change no state.
- R7: Trigger word 0 (at 0x5C) selects rising-edge capture for the sources whose bits it sets, and trigger word 1 (at 0x60) selects falling-edge capture. When both bits are set, either edge is captured. An edge-mode input held steady sets nothing.
- R8: `cpu_irq` is the OR of the identity bits, delayed by one register. It rises one cycle after the first identity bit sets and falls one cycle after the last identity bit clears.
- R9: Bits at and above NUM_SRC (bits 31..24 by default) read as zero in every register and are ignored on writes.
- R10: An input change driven before clock edge E1 reaches the pending bit at edge E3, after the two synchroniser flops. Read data is registered and shows, one edge after an address is presented, the state held before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the previous cycle's address |
| src_irq | input | NUM_SRC | Raw interrupt inputs, asynchronous |
| cpu_irq | output | 1 | Combined interrupt request |

## Verification
An input change driven before edge E1 is due in the pending bit after E3 and in `cpu_irq` after E4. A clear written at edge Ew drops `cpu_irq` after Ew+1. Read data is due one edge after its address. The bench drives inputs on falling edges and samples one nanosecond after the rising edge where each result is due. It checks the line both one edge early (old value) and on time (new value). The same-cycle clear-versus-capture case is arranged so that the write strobe and the third synchroniser edge fall on the same clock edge.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  // Byte offsets of the register file; software decodes these.
  localparam logic [7:0] OFF_PEND  = 8'h10;
  localparam logic [7:0] OFF_MASK  = 8'h18;
  localparam logic [7:0] OFF_MCLR  = 8'h1C;
  localparam logic [7:0] OFF_MSET  = 8'h20;
  localparam logic [7:0] OFF_IDENT = 8'h38;
  localparam logic [7:0] OFF_TRG0  = 8'h5C;
  localparam logic [7:0] OFF_TRG1  = 8'h60;
  localparam int unsigned BUS_W    = 32;
endpackage

// File: rtl/irq_agg_sync.sv
module irq_agg_sync #(
  parameter int unsigned WIDTH  = 24,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  logic [WIDTH-1:0] chain_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < STAGES; k++) chain_q[k] <= '0;
    end else begin
      chain_q[0] <= d_async;
      for (int k = 1; k < STAGES; k++) chain_q[k] <= chain_q[k-1];
    end
  end

  assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/irq_agg_capture.sv
module irq_agg_capture #(
  parameter int unsigned WIDTH = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] lvl,
  input  logic [WIDTH-1:0] rise_sel,
  input  logic [WIDTH-1:0] fall_sel,
  input  logic [WIDTH-1:0] clr,
  output logic [WIDTH-1:0] pend
);
  logic [WIDTH-1:0] prev_q;
  logic [WIDTH-1:0] pend_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= lvl;
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_src
    logic rise_ev, fall_ev, hit;
    always_comb begin
      rise_ev = lvl[i] & ~prev_q[i];
      fall_ev = ~lvl[i] & prev_q[i];
      if (rise_sel[i] | fall_sel[i])
        hit = (rise_sel[i] & rise_ev) | (fall_sel[i] & fall_ev);
      else
        hit = lvl[i];
    end
    // A capture in the same cycle as a clear wins.
    always_ff @(posedge clk) begin
      if (rst) pend_q[i] <= 1'b0;
      else     pend_q[i] <= (pend_q[i] & ~clr[i]) | hit;
    end
  end

  assign pend = pend_q;
endmodule

// File: rtl/irq_sticky_agg.sv
module irq_sticky_agg #(
  parameter int unsigned NUM_SRC = 24,
  parameter int unsigned ADDR_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NUM_SRC-1:0] src_irq,
  output logic              cpu_irq
);
  import irq_agg_pkg::*;

  localparam int unsigned PAD_W = BUS_W - NUM_SRC;

  logic [NUM_SRC-1:0] sync_q;
  logic [NUM_SRC-1:0] sticky_q;
  logic [NUM_SRC-1:0] en_q;
  logic [NUM_SRC-1:0] trig0_q;
  logic [NUM_SRC-1:0] trig1_q;
  logic [NUM_SRC-1:0] wbits;
  logic [NUM_SRC-1:0] pend_clr;
  logic [NUM_SRC-1:0] ident;
  logic [31:0]        rd_n;
  logic               cpu_irq_q;
  logic               hit_pend, hit_mask, hit_mclr, hit_mset;
  logic               hit_ident, hit_trg0, hit_trg1;

  assign wbits = bus_wdata[NUM_SRC-1:0];

  if (PAD_W > 0) begin : g_pad
    logic unused_hi;
    assign unused_hi = ^bus_wdata[31:NUM_SRC];
  end

  always_comb begin
    hit_pend  = (bus_addr == ADDR_W'(OFF_PEND));
    hit_mask  = (bus_addr == ADDR_W'(OFF_MASK));
    hit_mclr  = (bus_addr == ADDR_W'(OFF_MCLR));
    hit_mset  = (bus_addr == ADDR_W'(OFF_MSET));
    hit_ident = (bus_addr == ADDR_W'(OFF_IDENT));
    hit_trg0  = (bus_addr == ADDR_W'(OFF_TRG0));
    hit_trg1  = (bus_addr == ADDR_W'(OFF_TRG1));
  end

  irq_agg_sync #(.WIDTH(NUM_SRC), .STAGES(2)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async (src_irq),
    .q_sync  (sync_q)
  );

  assign pend_clr = (bus_we && hit_pend) ? wbits : '0;

  irq_agg_capture #(.WIDTH(NUM_SRC)) u_cap (
    .clk      (clk),
    .rst      (rst),
    .lvl      (sync_q),
    .rise_sel (trig0_q),
    .fall_sel (trig1_q),
    .clr      (pend_clr),
    .pend     (sticky_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= '0;
      trig0_q <= '0;
      trig1_q <= '0;
    end else if (bus_we) begin
      if (hit_mask) en_q    <= wbits;
      if (hit_mset) en_q    <= en_q | wbits;
      if (hit_mclr) en_q    <= en_q & ~wbits;
      if (hit_trg0) trig0_q <= wbits;
      if (hit_trg1) trig1_q <= wbits;
    end
  end

  assign ident = sticky_q & en_q;

  always_comb begin
    rd_n = '0;
    unique case (1'b1)
      hit_pend:  rd_n[NUM_SRC-1:0] = sticky_q;
      hit_mask:  rd_n[NUM_SRC-1:0] = en_q;
      hit_ident: rd_n[NUM_SRC-1:0] = ident;
      hit_trg0:  rd_n[NUM_SRC-1:0] = trig0_q;
      hit_trg1:  rd_n[NUM_SRC-1:0] = trig1_q;
      default:   rd_n = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      cpu_irq_q <= 1'b0;
    end else begin
      bus_rdata <= rd_n;
      cpu_irq_q <= |ident;
    end
  end

  assign cpu_irq = cpu_irq_q;
endmodule

// File: rtl/irq_sticky_agg_chk.sv
module irq_sticky_agg_chk #(
  parameter int unsigned NUM_SRC = 24,
  parameter int unsigned ADDR_W  = 8
) (
  input logic               clk,
  input logic               rst,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic               bus_we,
  input logic [31:0]        bus_wdata,
  input logic [31:0]        bus_rdata,
  input logic               cpu_irq,
  input logic [NUM_SRC-1:0] sync_q,
  input logic [NUM_SRC-1:0] sticky_q,
  input logic [NUM_SRC-1:0] en_q,
  input logic [NUM_SRC-1:0] trig0_q,
  input logic [NUM_SRC-1:0] trig1_q
);
  import irq_agg_pkg::*;

  logic rst_seen_q = 1'b0;

  // R1: the edge after a reset edge finds the request line low.
  always_ff @(posedge clk) begin
    rst_seen_q <= rst;
    if (rst_seen_q) assert_reset_quiet_R1 : assert (!cpu_irq);
  end

  // R9: upper read bits are always zero.
  if (NUM_SRC < 32) begin : g_hi
    always_ff @(posedge clk) begin
      if (!rst) assert_upper_zero_R9 : assert (bus_rdata[31:NUM_SRC] == '0);
    end
  end

  assert_level_sticky_R2 : assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((sticky_q & $past(sync_q & ~(trig0_q | trig1_q)))
              == $past(sync_q & ~(trig0_q | trig1_q))));

  assert_mask_set_R4 : assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == ADDR_W'(OFF_MSET)) |=>
      ((en_q & $past(bus_wdata[NUM_SRC-1:0])) == $past(bus_wdata[NUM_SRC-1:0])));

  assert_mask_clr_R4 : assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == ADDR_W'(OFF_MCLR)) |=>
      ((en_q & $past(bus_wdata[NUM_SRC-1:0])) == '0));

  assert_mask_zero_R5 : assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == ADDR_W'(OFF_MASK) && bus_wdata == 32'h0) |=> (en_q == '0));

  assert_irq_drop_R8 : assert property (@(posedge clk) disable iff (rst)
    ((sticky_q & en_q) == '0) |=> !cpu_irq);
endmodule

bind irq_sticky_agg irq_sticky_agg_chk #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_we    (bus_we),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .cpu_irq   (cpu_irq),
  .sync_q    (sync_q),
  .sticky_q  (sticky_q),
  .en_q      (en_q),
  .trig0_q   (trig0_q),
  .trig1_q   (trig1_q)
);

// File: tb/irq_sticky_agg_tb.sv
`timescale 1ns/1ps
module irq_sticky_agg_tb;
  localparam int N = 24;
  localparam logic [7:0] A_PEND = 8'h10, A_MASK = 8'h18, A_MCLR = 8'h1C,
                         A_MSET = 8'h20, A_IDENT = 8'h38, A_TRG0 = 8'h5C,
                         A_TRG1 = 8'h60;
  localparam logic [31:0] ALL = 32'h00FF_FFFF;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = 8'h0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic [N-1:0] src_irq = '0;
  logic        cpu_irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_sticky_agg #(.NUM_SRC(N), .ADDR_W(8)) u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_irq(src_irq),
    .cpu_irq(cpu_irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_addr = a;
    @(posedge clk);
    #1 v = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  logic [31:0] v;

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1 reset state
    chk("R1 cpu_irq", {31'b0, cpu_irq}, 32'h0);
    rd(A_PEND, v);  chk("R1 pend", v, 0);
    rd(A_MASK, v);  chk("R1 mask", v, 0);
    rd(A_TRG0, v);  chk("R1 trg0", v, 0);
    rd(A_TRG1, v);  chk("R1 trg1", v, 0);
    rd(A_IDENT, v); chk("R1 ident", v, 0);

    // R9 upper bits ignored
    wr(A_MASK, 32'hFFFF_FFFF); rd(A_MASK, v); chk("R9 mask upper", v, ALL);
    wr(A_TRG1, 32'hFF00_0000); rd(A_TRG1, v); chk("R9 trg1 upper", v, 0);
    // R5 direct zero masks all
    wr(A_MASK, 32'h0); rd(A_MASK, v); chk("R5 mask zero", v, 0);
    wr(A_MASK, 32'h00A5_0F0F); rd(A_MASK, v); chk("R5 mask direct", v, 32'h00A5_0F0F);
    // R4 aliases
    wr(A_MSET, 32'h0000_F000); rd(A_MASK, v); chk("R4 set", v, 32'h00A5_FF0F);
    wr(A_MCLR, 32'h00A0_000F); rd(A_MASK, v); chk("R4 clr", v, 32'h0005_FF00);
    wr(A_MASK, 32'h0);

    // Sweep every source in level mode: R2, R3, R6, R8, R10
    for (int i = 0; i < N; i++) begin
      logic [31:0] b;
      b = 32'h1 << i;
      wr(A_MSET, b);
      @(negedge clk) src_irq[i] = 1'b1;           // before E1
      @(negedge clk) src_irq[i] = 1'b0;
      // now past E1; E2 next, E3 captures
      @(posedge clk); #1;                           // after E2
      chk("R10 not yet", {31'b0, cpu_irq}, 0);
      @(posedge clk); #1;                           // after E3: pending set
      chk("R8 one cycle late", {31'b0, cpu_irq}, 0);
      @(posedge clk); #1;                           // after E4
      chk("R8 rise", {31'b0, cpu_irq}, 32'h1);
      rd(A_PEND, v);  chk("R2 level pulse pend", v, b);
      rd(A_IDENT, v); chk("R6 ident", v, b);
      // clear with zeros elsewhere, then check drop timing
      @(negedge clk); bus_addr = A_PEND; bus_we = 1'b1; bus_wdata = b;
      @(posedge clk); #1;                           // Ew
      bus_we = 1'b0;
      chk("R8 still high at Ew", {31'b0, cpu_irq}, 32'h1);
      @(posedge clk); #1;
      chk("R8 drop", {31'b0, cpu_irq}, 0);
      rd(A_PEND, v); chk("R3 cleared", v, 0);
      wr(A_MCLR, b);
    end

    // R6: pending but masked gives empty ident, no request
    @(negedge clk) src_irq[5] = 1'b1;
    @(negedge clk) src_irq[5] = 1'b0;
    idle(4);
    rd(A_PEND, v);  chk("R6 masked pend", v, 32'h20);
    rd(A_IDENT, v); chk("R6 masked ident", v, 0);
    chk("R8 masked no irq", {31'b0, cpu_irq}, 0);
    // R3 writing zeros leaves bit; R6 ident write ignored
    wr(A_PEND, 32'h0000_0000); rd(A_PEND, v); chk("R3 zero write", v, 32'h20);
    wr(A_IDENT, ALL); rd(A_PEND, v); chk("R6 ident write pend", v, 32'h20);
    rd(A_MASK, v); chk("R6 ident write mask", v, 0);
    wr(A_PEND, 32'hFFFF_FFFF); rd(A_PEND, v); chk("R3 all ones", v, 0);

    // R2 override: held-high level input cannot be cleared
    src_irq[7] = 1'b1; idle(4);
    wr(A_PEND, 32'h80); rd(A_PEND, v); chk("R2 override", v, 32'h80);
    src_irq[7] = 1'b0; idle(4);
    wr(A_PEND, 32'h80); rd(A_PEND, v); chk("R2 released", v, 0);

    // R7 rising-only on source 2
    wr(A_TRG0, 32'h4);
    src_irq[2] = 1'b1; idle(5);
    rd(A_PEND, v); chk("R7 rise capture", v, 32'h4);
    wr(A_PEND, 32'h4); idle(3);
    rd(A_PEND, v); chk("R7 steady high nothing", v, 0);
    src_irq[2] = 1'b0; idle(5);
    rd(A_PEND, v); chk("R7 fall ignored in rise mode", v, 0);
    // R7 falling-only on source 9
    wr(A_TRG1, 32'h200);
    src_irq[9] = 1'b1; idle(5);
    rd(A_PEND, v); chk("R7 rise ignored in fall mode", v, 0);
    src_irq[9] = 1'b0; idle(5);
    rd(A_PEND, v); chk("R7 fall capture", v, 32'h200);
    wr(A_PEND, ALL);
    // R7 both edges on source 11
    wr(A_TRG0, 32'h800); wr(A_TRG1, 32'h800);
    src_irq[11] = 1'b1; idle(5);
    rd(A_PEND, v); chk("R7 both rise", v, 32'h800);
    wr(A_PEND, ALL); idle(2);
    src_irq[11] = 1'b0; idle(5);
    rd(A_PEND, v); chk("R7 both fall", v, 32'h800);
    wr(A_PEND, ALL);

    // R3 capture beats clear in the same cycle (source 3 rising)
    wr(A_TRG0, 32'h8); wr(A_TRG1, 32'h0);
    @(negedge clk) src_irq[3] = 1'b1;              // before E1
    @(negedge clk);                                 // after E1
    @(negedge clk);                                 // after E2
    bus_addr = A_PEND; bus_we = 1'b1; bus_wdata = 32'h8;
    @(negedge clk) bus_we = 1'b0;                   // E3 had both
    rd(A_PEND, v); chk("R3 capture wins", v, 32'h8);
    wr(A_PEND, ALL); rd(A_PEND, v); chk("R3 edge cleared after", v, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule